// File: doc/BRIEF.md
# Parallel Bus Asynchronous Write Engine

This block moves outbound data-phase bytes onto an 8-bit parallel peripheral bus that uses a request/acknowledge handshake for each byte. The host side supplies byte pairs. Each byte gets an odd parity bit, and the pair is packed into one 32-bit word. The low byte's 9-bit code sits in bits [15:0] and the high byte's code sits in bits [31:16], with zero padding above each code. Words are staged in two banks that alternate. One bank is drained toward the bus while the other refills.

The bus is active low. A byte is driven inverted on nine lines (eight data lines plus parity). REQ is pulled low once the data has been held for a set number of clocks. The target answers by pulling ACK low. REQ is then released, and the next byte waits until ACK is high again. Completion is reported in two steps. First, a feed-done state says that nothing is left to stage. Then a one-cycle drained pulse marks the point where the last handshake has closed and ACK is high. If the bus stalls after the feed is done, a watchdog aborts the session and raises a sticky timeout flag.

Top module: `scsi_wr_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, bus_oe_o is 0, req_no is 1, db_no is all ones and pair_ready_o is 0.
- R2: A start_i pulse in idle sets bus_oe_o to 1 on the next clock. req_no and db_no stay high until the first byte is presented.
- R3: Each byte b is driven as db_no[7:0] = ~b and db_no[8] = ~p, where p is the odd parity bit (p = 1 exactly when b has an even number of ones).
- R4: Within a pair, pair_i[7:0] goes on the bus before pair_i[15:8]. Pairs go out in the order they were accepted.
- R5: db_no is held for at least SETUP_CYC clocks before req_no falls, and it stays unchanged while req_no is low.
- R6: req_no falls only while ACK is high. req_no rises only after ACK has gone low. The next byte waits for ACK to return high.
- R7: No byte is sent until both banks (BUF_WORDS words each) are full, or until the pair marked pair_last_i has been accepted. The first byte sent comes from the first pair accepted.
- R8: While both banks hold unsent words, pair_ready_o stays 0. A bank is refilled only after all its words have been sent.
- R9: feed_done_o is asserted once the last pair has left the banks. This can happen while bytes are still pending on the bus. While feed_done_o is high, pair_ready_o is 0.
- R10: drained_o pulses for one clock only after the final byte's handshake has closed with ACK high. bus_oe_o is 0 on the following clock.
- R11: If the bus does not drain within TIMEOUT_CYC clocks of feed_done_o, the engine returns to idle and sets timeout_o. timeout_o stays set until the next start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a write session (taken only in idle) |
| pair_valid_i | input | 1 | Byte pair offered |
| pair_i | input | 16 | Byte pair, low byte sent first |
| pair_last_i | input | 1 | Offered pair is the final one of the session |
| pair_ready_o | output | 1 | Pair accepted on this clock when valid |
| ack_ni | input | 1 | Target acknowledge, active low, asynchronous |
| db_no | output | 9 | Data lines [7:0] and parity [8], active low |
| req_no | output | 1 | Request strobe, active low |
| bus_oe_o | output | 1 | Engine owns data and REQ lines |
| feed_done_o | output | 1 | No more words to stage |
| drained_o | output | 1 | One-clock pulse: session ended cleanly |
| timeout_o | output | 1 | Sticky: session aborted by drain watchdog |

## Verification
The two functions that most often collide are the refill of one bank by the host and the drain of the other bank into the handshake stage. This includes the clock on which the drain bank empties and changes roles while a push lands in the bank just freed. The bench provokes this with ACK answered at zero delay and a continuous stream of pairs that ends in a partly filled bank. A scoreboard compares every byte seen at each falling REQ against the queue of expected codes. Any reordering, loss or duplication at a bank switch therefore shows up as a miscompare.

// File: rtl/scsi_wr_pkg.sv
package scsi_wr_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_WRITE, ENG_WDONE} eng_state_e;
  typedef enum logic [1:0] {PH_EMPTY, PH_SETUP, PH_REQ, PH_REL} ph_state_e;

  // odd parity: bit set when the byte alone has an even count of ones
  function automatic logic [15:0] byte_code(input logic [7:0] b);
    return {7'd0, ~^b, b};
  endfunction

  function automatic logic [31:0] pack_pair(input logic [15:0] pr);
    return {byte_code(pr[15:8]), byte_code(pr[7:0])};
  endfunction
endpackage

// File: rtl/scsi_wr_stage.sv
module scsi_wr_stage #(
  parameter int BUF_WORDS = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        push_i,
  input  logic        push_last_i,
  input  logic [31:0] push_word_i,
  output logic        push_ready_o,
  input  logic        pop_i,
  output logic        avail_o,
  output logic [31:0] pop_word_o,
  output logic        feed_empty_o
);
  localparam int PW = $clog2(BUF_WORDS);
  localparam int CW = PW + 1;

  logic [31:0]   mem_q [2][BUF_WORDS];
  logic [CW-1:0] cnt_q [2];
  logic [1:0]    sealed_q;
  logic          fill_sel_q, drain_sel_q, last_q, primed_q;
  logic [PW-1:0] wptr_q, rptr_q;
  logic          push_acc;

  assign push_ready_o = en_i && !last_q && !sealed_q[fill_sel_q];
  assign push_acc     = push_i && push_ready_o;
  assign avail_o      = primed_q && sealed_q[drain_sel_q];
  assign pop_word_o   = mem_q[drain_sel_q][rptr_q];
  assign feed_empty_o = last_q && (sealed_q == 2'b00);

  always_ff @(posedge clk_i) begin
    if (push_acc) mem_q[fill_sel_q][wptr_q] <= push_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sealed_q <= '0; fill_sel_q <= 1'b0; drain_sel_q <= 1'b0;
      wptr_q <= '0; rptr_q <= '0; last_q <= 1'b0; primed_q <= 1'b0;
      for (int b = 0; b < 2; b++) cnt_q[b] <= '0;
    end else if (clr_i) begin
      sealed_q <= '0; fill_sel_q <= 1'b0; drain_sel_q <= 1'b0;
      wptr_q <= '0; rptr_q <= '0; last_q <= 1'b0; primed_q <= 1'b0;
    end else begin
      if (push_acc) begin
        wptr_q <= wptr_q + 1'b1;
        if (wptr_q == PW'(BUF_WORDS - 1) || push_last_i) begin
          sealed_q[fill_sel_q] <= 1'b1;
          cnt_q[fill_sel_q]    <= CW'(wptr_q) + CW'(1);
          fill_sel_q           <= ~fill_sel_q;
          wptr_q               <= '0;
        end
        if (push_last_i) last_q <= 1'b1;
      end
      if (pop_i) begin
        rptr_q <= rptr_q + 1'b1;
        if (CW'(rptr_q) + CW'(1) == cnt_q[drain_sel_q]) begin
          sealed_q[drain_sel_q] <= 1'b0;
          drain_sel_q           <= ~drain_sel_q;
          rptr_q                <= '0;
        end
      end
      if (!primed_q && ((&sealed_q) || last_q)) primed_q <= 1'b1;
    end
  end

  // refill and drain on one clock must touch different banks
  p_split_banks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_acc && pop_i) |-> (fill_sel_q != drain_sel_q));
  p_pop_avail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> avail_o);
endmodule

// File: rtl/scsi_wr_hs.sv
module scsi_wr_hs
  import scsi_wr_pkg::*;
#(
  parameter int SETUP_CYC = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        word_valid_i,
  input  logic [31:0] word_i,
  output logic        take_o,
  output logic        empty_o,
  input  logic        ack_i,
  output logic [8:0]  db_no,
  output logic        req_no
);
  localparam int SW = $clog2(SETUP_CYC) + 1;

  ph_state_e     st_q;
  logic [8:0]    db_q, hi_code_q;
  logic          req_q, hi_q;
  logic [SW-1:0] scnt_q;

  assign empty_o = (st_q == PH_EMPTY);
  assign take_o  = empty_o && word_valid_i && !clr_i;
  assign db_no   = db_q;
  assign req_no  = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PH_EMPTY; db_q <= '1; req_q <= 1'b1; hi_q <= 1'b0;
      hi_code_q <= '0; scnt_q <= '0;
    end else if (clr_i) begin
      st_q <= PH_EMPTY; db_q <= '1; req_q <= 1'b1; hi_q <= 1'b0;
    end else begin
      unique case (st_q)
        PH_EMPTY: if (word_valid_i) begin
          db_q      <= ~word_i[8:0];
          hi_code_q <= word_i[24:16];
          hi_q      <= 1'b0;
          scnt_q    <= SW'(SETUP_CYC - 1);
          st_q      <= PH_SETUP;
        end
        PH_SETUP: if (scnt_q == '0) begin
          req_q <= 1'b0;
          st_q  <= PH_REQ;
        end else scnt_q <= scnt_q - 1'b1;
        PH_REQ: if (!ack_i) begin
          req_q <= 1'b1;
          st_q  <= PH_REL;
        end
        PH_REL: if (ack_i) begin
          if (!hi_q) begin
            db_q   <= ~hi_code_q;
            hi_q   <= 1'b1;
            scnt_q <= SW'(SETUP_CYC - 1);
            st_q   <= PH_SETUP;
          end else begin
            db_q <= '1;
            st_q <= PH_EMPTY;
          end
        end
        default: st_q <= PH_EMPTY;
      endcase
    end
  end

  p_code_pad_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (word_i[15:9] == '0 && word_i[31:25] == '0));
  p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_q && $past(!req_q)) |-> $stable(db_q));
  p_req_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_q) |-> $past(ack_i));
  p_req_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_q) && !$past(clr_i)) |-> $past(!ack_i));
endmodule

// File: rtl/scsi_wr_engine.sv
module scsi_wr_engine
  import scsi_wr_pkg::*;
#(
  parameter int BUF_WORDS   = 128,
  parameter int SETUP_CYC   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        pair_valid_i,
  input  logic [15:0] pair_i,
  input  logic        pair_last_i,
  output logic        pair_ready_o,
  input  logic        ack_ni,
  output logic [8:0]  db_no,
  output logic        req_no,
  output logic        bus_oe_o,
  output logic        feed_done_o,
  output logic        drained_o,
  output logic        timeout_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  eng_state_e           st_q;
  logic [TW-1:0]        tcnt_q;
  logic [SYNC_STAGES-1:0] ack_sr_q;
  logic                 ack_s, go, fin, abort, hs_clr;
  logic                 avail, take, hs_empty, feed_empty, drained_q, timeout_q;
  logic [31:0]          word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_sr_q <= '1;
    else         ack_sr_q <= {ack_sr_q[SYNC_STAGES-2:0], ack_ni};
  end
  assign ack_s = ack_sr_q[SYNC_STAGES-1];

  assign go     = (st_q == ENG_IDLE) && start_i;
  assign fin    = (st_q == ENG_WDONE) && hs_empty && ack_s;
  assign abort  = (st_q == ENG_WDONE) && !fin && (tcnt_q == TW'(TIMEOUT_CYC - 1));
  assign hs_clr = go || abort;

  scsi_wr_stage #(.BUF_WORDS(BUF_WORDS)) u_stage (
    .clk_i, .rst_ni, .clr_i(go), .en_i(st_q == ENG_WRITE),
    .push_i(pair_valid_i), .push_last_i(pair_last_i),
    .push_word_i(pack_pair(pair_i)), .push_ready_o(pair_ready_o),
    .pop_i(take), .avail_o(avail), .pop_word_o(word), .feed_empty_o(feed_empty)
  );

  scsi_wr_hs #(.SETUP_CYC(SETUP_CYC)) u_hs (
    .clk_i, .rst_ni, .clr_i(hs_clr), .word_valid_i(avail), .word_i(word),
    .take_o(take), .empty_o(hs_empty), .ack_i(ack_s), .db_no, .req_no
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ENG_IDLE; tcnt_q <= '0; drained_q <= 1'b0; timeout_q <= 1'b0;
    end else begin
      drained_q <= 1'b0;
      unique case (st_q)
        ENG_IDLE: if (start_i) begin
          st_q      <= ENG_WRITE;
          timeout_q <= 1'b0;
        end
        ENG_WRITE: if (feed_empty) begin
          st_q   <= ENG_WDONE;
          tcnt_q <= '0;
        end
        ENG_WDONE: begin
          if (fin) begin
            st_q      <= ENG_IDLE;
            drained_q <= 1'b1;
          end else if (abort) begin
            st_q      <= ENG_IDLE;
            timeout_q <= 1'b1;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign bus_oe_o    = (st_q != ENG_IDLE);
  assign feed_done_o = (st_q == ENG_WDONE);
  assign drained_o   = drained_q;
  assign timeout_o   = timeout_q;

  p_idle_released_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ENG_IDLE) |-> (req_no && db_no == '1));
  p_feed_done_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_done_o |-> !pair_ready_o);
  p_drained_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drained_o |-> ($past(ack_s) && req_no && !bus_oe_o));
  p_timeout_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (st_q == ENG_IDLE && !drained_o));
endmodule

// File: tb/scsi_wr_engine_test.sv
module scsi_wr_engine_test;
  localparam int BW = 4, SU = 2, TO = 60;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pv = 1'b0, plast = 1'b0, ack_n = 1'b1;
  logic [15:0] pd = '0;
  logic pr, req_n, oe, fd, drained, tout;
  logic [8:0] db;

  always #2.5 clk = ~clk;

  scsi_wr_engine #(.BUF_WORDS(BW), .SETUP_CYC(SU), .SYNC_STAGES(2), .TIMEOUT_CYC(TO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pair_valid_i(pv), .pair_i(pd),
    .pair_last_i(plast), .pair_ready_o(pr), .ack_ni(ack_n), .db_no(db), .req_no(req_n),
    .bus_oe_o(oe), .feed_done_o(fd), .drained_o(drained), .timeout_o(tout)
  );

  int n_vec = 0, n_bad = 0, cyc = 0, nbytes = 0, stable = 0, ack_dly = 1, dcnt = 0;
  logic [7:0] exp_q[$];
  bit freeze = 0, hold_low = 0, fd_busy = 0, drained_seen = 0, chk_oe_next = 0, ended = 0;
  logic [8:0] db_prev = '1;
  logic req_prev = 1'b1;

  task automatic chk(bit ok, string rq, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_code(logic [7:0] b);
    logic p;
    p = ($countones(b) % 2 == 0);
    return ~{p, b};
  endfunction

  // monitor, scoreboard and bus target
  always @(negedge clk) begin
    if (chk_oe_next) begin chk(oe == 1'b0, "R10", oe, 0); chk_oe_next = 0; end
    stable = (db == db_prev) ? stable + 1 : 0;
    if (req_prev && !req_n) begin
      chk(ack_n == 1'b1, "R6", ack_n, 1);
      chk(stable >= SU, "R5", stable, SU);
      if (exp_q.size() == 0) chk(0, "R4", db, 0);
      else begin
        logic [7:0] b;
        b = exp_q.pop_front();
        chk(db == exp_code(b), "R3/R4", db, exp_code(b));
      end
      nbytes++;
    end
    if (!req_prev && req_n && oe) chk(ack_n == 1'b0, "R6", ack_n, 0);
    if (fd && exp_q.size() > 0) fd_busy = 1;
    if (drained) begin
      drained_seen = 1;
      chk(exp_q.size() == 0 && ack_n, "R10", exp_q.size(), 0);
      chk_oe_next = 1;
    end
    if (!freeze) begin
      if (!req_n && ack_n) begin
        if (dcnt >= ack_dly) begin ack_n = 1'b0; dcnt = 0; end else dcnt++;
      end else if (req_n && !ack_n && !hold_low) begin
        if (dcnt >= ack_dly) begin ack_n = 1'b1; dcnt = 0; end else dcnt++;
      end
    end
    req_prev = req_n;
    db_prev  = db;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  function automatic logic [15:0] pat(int i);
    return 16'(i * 16'h1d3b + 16'h00a5);
  endfunction

  task automatic push(logic [15:0] d, bit last);
    exp_q.push_back(d[7:0]);
    exp_q.push_back(d[15:8]);
    pv = 1'b1; pd = d; plast = last;
    forever begin
      if (pr) begin @(negedge clk); break; end
      @(negedge clk);
    end
    pv = 1'b0; plast = 1'b0;
  endtask

  task automatic begin_xfer();
    nbytes = 0; fd_busy = 0; drained_seen = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_drained(string rq);
    for (int i = 0; i < 5000 && !drained_seen; i++) @(negedge clk);
    chk(drained_seen, rq, drained_seen, 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(oe == 1'b0, "R1", oe, 0);
    chk(req_n == 1'b1 && db == 9'h1ff, "R1", {req_n, db}, 10'h3ff);
    chk(pr == 1'b0, "R1", pr, 0);

    // R2 / R7 / R9 / R10: full banks, last on final word
    ack_dly = 1;
    begin_xfer();
    chk(oe == 1'b1, "R2", oe, 1);
    chk(req_n == 1'b1 && db == 9'h1ff, "R2", {req_n, db}, 10'h3ff);
    for (int i = 0; i < 2 * BW - 1; i++) push(pat(i), 0);
    repeat (12) @(negedge clk);
    chk(req_n == 1'b1 && nbytes == 0, "R7", nbytes, 0);
    push(pat(2 * BW - 1), 1);
    wait_drained("R10");
    chk(fd_busy, "R9", fd_busy, 1);
    chk(nbytes == 4 * BW, "R4", nbytes, 4 * BW);

    // R4 / R8: zero-delay target, refill overlaps drain, partial last bank
    ack_dly = 0;
    begin_xfer();
    push(16'h0000, 0); push(16'hffff, 0); push(16'h8001, 0); push(16'h7f80, 0);
    for (int i = 0; i < 5; i++) push(pat(i + 40), 0);
    push(16'h0102, 1);
    wait_drained("R10");
    chk(nbytes == 20, "R4", nbytes, 20);
    chk(exp_q.size() == 0, "R4", exp_q.size(), 0);

    // R8: bus frozen, both banks full blocks the host
    ack_dly = 1; freeze = 1;
    begin_xfer();
    for (int i = 0; i < 2 * BW; i++) push(pat(i + 90), 0);
    repeat (15) @(negedge clk);
    chk(pr == 1'b0, "R8", pr, 0);
    chk(nbytes == 1, "R8", nbytes, 1);
    freeze = 0;
    for (int i = 0; i < 3; i++) push(pat(i + 120), i == 2);
    wait_drained("R10");
    chk(nbytes == 4 * BW + 6, "R8", nbytes, 4 * BW + 6);

    // R11: target holds ACK low after the first byte
    hold_low = 1;
    begin_xfer();
    push(16'h5aa5, 1);
    for (int i = 0; i < 300 && !tout; i++) @(negedge clk);
    chk(tout == 1'b1, "R11", tout, 1);
    chk(oe == 1'b0, "R11", oe, 0);
    chk(drained_seen == 0, "R11", drained_seen, 0);
    chk(req_n == 1'b1 && db == 9'h1ff, "R1", {req_n, db}, 10'h3ff);
    exp_q.delete();
    hold_low = 0;
    repeat (6) @(negedge clk);
    chk(tout == 1'b1, "R11", tout, 1);
    begin_xfer();
    chk(tout == 1'b0, "R11", tout, 0);
    push(16'hc33c, 1);
    wait_drained("R10");
    chk(nbytes == 2, "R4", nbytes, 2);

    ended = 1;
    summary();
    $finish;
  end
endmodule